// File: doc/BRIEF.md
# Wiper Tap Select with Shutdown

This block drives the tap switches of one resistor string in a digitally trimmed potentiometer. A stored 7-bit wiper code selects one of 128 tap-switch enables. Code 0 picks the tap nearest the low terminal and code 127 picks the tap nearest the high terminal. When the code changes, the block runs a make-before-break sequence. The new tap closes and both taps stay closed for a set number of clock cycles. Only then does the old tap open, so the wiper never floats.

A shutdown control, `run_en`, is active low. When it is low, the block opens every tap and the high-end switch, and closes the switch that ties the wiper to the low terminal. The stored code is kept. When shutdown is released, the wiper comes back in two steps: the tap closes first, and the high-end switch closes on the next cycle. A brown-out flag seen while shutdown is asserted resets the stored code to mid-scale. Power-on reset also loads mid-scale.

The FSM has four states:
- `ST_HOLD`: one tap is closed and the high end is connected.
- `ST_OVERLAP`: the old and new taps are both closed.
- `ST_SHDN`: all taps are open and the wiper is tied low.
- `ST_WAKE`: the tap is closed but the high end is still open.

Its transitions are:
- `ST_HOLD` to `ST_OVERLAP`: the stored code differs from the current tap.
- `ST_OVERLAP` to `ST_HOLD`: the overlap count has expired.
- Any state other than `ST_SHDN` to `ST_SHDN`: shutdown is asserted.
- `ST_SHDN` to `ST_WAKE`: shutdown is released.
- `ST_WAKE` to `ST_HOLD`: the next cycle after `ST_WAKE`, unless shutdown is asserted again.

Top module: `wiper_tap_select`

## Requirements
- R1: While `rst_n` is low and after it is released, `tap_en` has only bit 64 high, `hi_en` is 1 and `lo_tie_en` is 0.
- R2: In steady state, a stored code c has `tap_en` bit c as its only high bit. Code 0 maps to bit 0 (low end) and code 127 maps to bit 127 (high end).
- R3: A write with `code_wr`=1 is sampled at clock edge k with a code that differs from the current tap. From edge k+1, the old and new bits are both high for OVERLAP_CYC cycles. After that, only the new bit is high. The enable never jumps directly from one single tap to another.
- R4: While `lo_tie_en` is 0, `tap_en` has one or two bits high and is never all zero.
- R5: A code written during an overlap is stored. It is applied by a second overlap that starts one cycle after the first one completes.
- R6: `run_en` is sampled 0 at an edge. After that edge, `tap_en` is all zero, `hi_en` is 0 and `lo_tie_en` is 1.
- R7: The stored code is retained through shutdown, and writes made during shutdown are stored. On the edge that samples `run_en`=1, the block restores in two steps:
  - After that edge, the stored code's tap bit is high with `hi_en`=0 and `lo_tie_en`=0.
  - One edge later, `hi_en` returns to 1 with the same tap.
- R8: `brownout`=1 sampled while `run_en`=0 sets the stored code to 64. This takes priority over a write in the same cycle.
- R9: `brownout`=1 while `run_en`=1 has no effect on the stored code or the outputs.
- R10: Shutdown asserted during an overlap aborts the transition. On release, the wiper lands on the latest stored code.
- R11: `hi_en` and `lo_tie_en` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, loads mid-scale |
| code_in | input | TAP_BITS | New wiper code |
| code_wr | input | 1 | Write strobe for `code_in` |
| run_en | input | 1 | Shutdown control, 0 = shutdown, 1 = normal |
| brownout | input | 1 | Supply-glitch flag |
| tap_en | output | 2**TAP_BITS | Tap switch enables, bit i = tap i |
| hi_en | output | 1 | High-end string switch enable |
| lo_tie_en | output | 1 | Wiper-to-low shutdown switch enable |

## Verification
The assertions assume that every input is synchronous to `clk` and holds steady for a whole cycle. They also assume that `rst_n` starts low, so the mid-scale state holds before any property is enabled. Any code value and any mix of strobes is legal, so the properties place no limit on `code_in` or on when writes, shutdown and brown-out arrive. The stimulus changes all inputs on the falling edge only. It puts writes inside overlaps, shutdown inside an overlap, and a brown-out together with a write, all while staying synchronous.

// File: rtl/wtap_pkg.sv
package wtap_pkg;
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_OVERLAP = 2'd1,
        ST_SHDN    = 2'd2,
        ST_WAKE    = 2'd3
    } wtap_state_e;
endpackage

// File: rtl/wtap_code_store.sv
module wtap_code_store #(
    parameter int TAP_BITS = 7,
    parameter logic [TAP_BITS-1:0] MID_CODE = 7'd64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                code_wr,
    input  logic [TAP_BITS-1:0] code_in,
    input  logic                run_en,
    input  logic                brownout,
    output logic [TAP_BITS-1:0] want_code
);
    // Supply glitch while parked low wins over any write in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            want_code <= MID_CODE;
        else if (!run_en && brownout)
            want_code <= MID_CODE;
        else if (code_wr)
            want_code <= code_in;
    end
endmodule

// File: rtl/wtap_onehot.sv
module wtap_onehot #(
    parameter int TAP_BITS = 7,
    parameter int NUM_TAPS = 128
) (
    input  logic [TAP_BITS-1:0] code,
    input  logic                en,
    output logic [NUM_TAPS-1:0] vec
);
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        assign vec[g] = en && (code == TAP_BITS'(g));
    end
endmodule

// File: rtl/wtap_fsm.sv
module wtap_fsm
    import wtap_pkg::*;
#(
    parameter int TAP_BITS = 7,
    parameter logic [TAP_BITS-1:0] MID_CODE = 7'd64,
    parameter int OVERLAP_CYC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_en,
    input  logic [TAP_BITS-1:0] want_code,
    output logic [TAP_BITS-1:0] cur_code,
    output logic [TAP_BITS-1:0] tgt_code,
    output logic                use_cur,
    output logic                use_tgt,
    output logic                hi_en,
    output logic                lo_tie_en
);
    localparam int CNT_W = (OVERLAP_CYC > 1) ? $clog2(OVERLAP_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERLAP_CYC - 1);

    wtap_state_e         state, state_d;
    logic [TAP_BITS-1:0] cur_d, tgt_d;
    logic [CNT_W-1:0]    cnt, cnt_d;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_HOLD;
            cur_code <= MID_CODE;
            tgt_code <= MID_CODE;
            cnt      <= '0;
        end else begin
            state    <= state_d;
            cur_code <= cur_d;
            tgt_code <= tgt_d;
            cnt      <= cnt_d;
        end
    end

    // Transition logic
    always_comb begin
        state_d = state;
        cur_d   = cur_code;
        tgt_d   = tgt_code;
        cnt_d   = cnt;
        unique case (state)
            ST_HOLD: begin
                if (!run_en) begin
                    state_d = ST_SHDN;
                end else if (want_code != cur_code) begin
                    state_d = ST_OVERLAP;
                    tgt_d   = want_code;
                    cnt_d   = '0;
                end
            end
            ST_OVERLAP: begin
                if (!run_en) begin
                    state_d = ST_SHDN;
                end else if (cnt == CNT_LAST) begin
                    state_d = ST_HOLD;
                    cur_d   = tgt_code;
                end else begin
                    cnt_d = cnt + 1'b1;
                end
            end
            ST_SHDN: begin
                if (run_en) begin
                    state_d = ST_WAKE;
                    cur_d   = want_code;
                end
            end
            ST_WAKE: begin
                state_d = run_en ? ST_HOLD : ST_SHDN;
            end
        endcase
    end

    // Output process
    always_comb begin
        use_cur   = 1'b0;
        use_tgt   = 1'b0;
        hi_en     = 1'b0;
        lo_tie_en = 1'b0;
        unique case (state)
            ST_HOLD: begin
                use_cur = 1'b1;
                hi_en   = 1'b1;
            end
            ST_OVERLAP: begin
                use_cur = 1'b1;
                use_tgt = 1'b1;
                hi_en   = 1'b1;
            end
            ST_SHDN: begin
                lo_tie_en = 1'b1;
            end
            ST_WAKE: begin
                use_cur = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/wiper_tap_select.sv
module wiper_tap_select #(
    parameter int TAP_BITS    = 7,
    parameter int OVERLAP_CYC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [TAP_BITS-1:0]       code_in,
    input  logic                      code_wr,
    input  logic                      run_en,
    input  logic                      brownout,
    output logic [(1<<TAP_BITS)-1:0]  tap_en,
    output logic                      hi_en,
    output logic                      lo_tie_en
);
    localparam int NUM_TAPS = 1 << TAP_BITS;
    localparam logic [TAP_BITS-1:0] MID_CODE = TAP_BITS'(NUM_TAPS / 2);

    logic [TAP_BITS-1:0] want_code, cur_code, tgt_code;
    logic                use_cur, use_tgt;
    logic [NUM_TAPS-1:0] cur_vec, tgt_vec;

    wtap_code_store #(.TAP_BITS(TAP_BITS), .MID_CODE(MID_CODE)) u_store (
        .clk(clk), .rst_n(rst_n), .code_wr(code_wr), .code_in(code_in),
        .run_en(run_en), .brownout(brownout), .want_code(want_code)
    );

    wtap_fsm #(.TAP_BITS(TAP_BITS), .MID_CODE(MID_CODE), .OVERLAP_CYC(OVERLAP_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .want_code(want_code),
        .cur_code(cur_code), .tgt_code(tgt_code), .use_cur(use_cur),
        .use_tgt(use_tgt), .hi_en(hi_en), .lo_tie_en(lo_tie_en)
    );

    wtap_onehot #(.TAP_BITS(TAP_BITS), .NUM_TAPS(NUM_TAPS)) u_dec_cur (
        .code(cur_code), .en(use_cur), .vec(cur_vec)
    );

    wtap_onehot #(.TAP_BITS(TAP_BITS), .NUM_TAPS(NUM_TAPS)) u_dec_tgt (
        .code(tgt_code), .en(use_tgt), .vec(tgt_vec)
    );

    assign tap_en = cur_vec | tgt_vec;
endmodule

// File: rtl/wiper_tap_select_chk.sv
module wiper_tap_select_chk #(
    parameter int NUM_TAPS    = 128,
    parameter int OVERLAP_CYC = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                run_en,
    input logic [NUM_TAPS-1:0] tap_en,
    input logic                hi_en,
    input logic                lo_tie_en
);
    logic [15:0] ovl_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ovl_run <= '0;
        else if ($countones(tap_en) == 2)
            ovl_run <= ovl_run + 16'd1;
        else
            ovl_run <= '0;
    end

    // R4
    tap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_tie_en |-> ($countones(tap_en) == 1 || $countones(tap_en) == 2));

    // R6
    shdn_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (lo_tie_en && !hi_en && tap_en == '0));

    // R11
    sw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_en && lo_tie_en));

    // R7
    wake_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lo_tie_en) |-> (!hi_en && $countones(tap_en) == 1));

    // R7
    hi_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_en) |-> ($stable(tap_en) && $countones(tap_en) == 1));

    // R3
    mbb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_tie_en && !$past(lo_tie_en) && $countones(tap_en) == 1
         && $countones($past(tap_en)) == 1) |-> $stable(tap_en));

    // R3
    ovl_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_run <= 16'(OVERLAP_CYC));
endmodule

bind wiper_tap_select wiper_tap_select_chk #(
    .NUM_TAPS(NUM_TAPS), .OVERLAP_CYC(OVERLAP_CYC)
) u_chk (.*);

// File: tb/wiper_tap_select_bench.sv
module wiper_tap_select_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TB_BITS    = 7;
    localparam int TB_TAPS    = 128;
    localparam int OVL        = 2;
    localparam int MID        = 64;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [TB_BITS-1:0] code_in = '0;
    logic               code_wr = 1'b0;
    logic               run_en = 1'b1;
    logic               brownout = 1'b0;
    logic [TB_TAPS-1:0] tap_en;
    logic               hi_en, lo_tie_en;

    typedef struct {
        int    ta;
        int    tb;
        bit    hi;
        bit    lo;
        string req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   exp_cur = MID;
    bit   done = 1'b0;

    wiper_tap_select #(.TAP_BITS(TB_BITS), .OVERLAP_CYC(OVL)) u_wiper_tap_select (
        .clk(clk), .rst_n(rst_n), .code_in(code_in), .code_wr(code_wr),
        .run_en(run_en), .brownout(brownout), .tap_en(tap_en),
        .hi_en(hi_en), .lo_tie_en(lo_tie_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic compare(input exp_t e);
        logic [TB_TAPS-1:0] ev;
        ev = '0;
        if (e.ta >= 0) ev[e.ta] = 1'b1;
        if (e.tb >= 0) ev[e.tb] = 1'b1;
        checks++;
        if (tap_en !== ev || hi_en !== e.hi || lo_tie_en !== e.lo) begin
            errors++;
            $display("FAIL %s: tap_en=%h hi=%b lo=%b expected tap_en=%h hi=%b lo=%b",
                     e.req, tap_en, hi_en, lo_tie_en, ev, e.hi, e.lo);
        end
    endtask

    // Driver: one input set and one expected item per cycle
    task automatic step(input bit wr, input int code, input bit run, input bit bo,
                        input int ta, input int tb, input bit hi, input bit lo,
                        input string req);
        exp_t e;
        @(negedge clk);
        code_wr  = wr;
        code_in  = code[TB_BITS-1:0];
        run_en   = run;
        brownout = bo;
        e.ta = ta; e.tb = tb; e.hi = hi; e.lo = lo; e.req = req;
        q.push_back(e);
    endtask

    task automatic hold(input int n, input string req);
        repeat (n) step(0, 0, 1, 0, exp_cur, -1, 1, 0, req);
    endtask

    task automatic move(input int code, input string req);
        step(1, code, 1, 0, exp_cur, -1, 1, 0, req);
        repeat (OVL) step(0, 0, 1, 0, exp_cur, code, 1, 0, req);
        exp_cur = code;
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (q.size() > 0) compare(q.pop_front());
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        exp_t r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        r.ta = MID; r.tb = -1; r.hi = 1'b1; r.lo = 1'b0; r.req = "R1 in reset";
        compare(r);
        rst_n = 1'b1;
        hold(2, "R1");

        // R2 / R3 boundaries and a mid move
        move(0, "R3");
        hold(1, "R2 low end");
        move(127, "R3");
        hold(1, "R2 high end");
        move(5, "R3");
        hold(1, "R4");

        // R5: second write inside the overlap
        step(1, 40, 1, 0, 5, -1, 1, 0, "R5");
        step(1, 90, 1, 0, 5, 40, 1, 0, "R5");
        repeat (OVL-1) step(0, 0, 1, 0, 5, 40, 1, 0, "R5");
        step(0, 0, 1, 0, 40, -1, 1, 0, "R5");
        repeat (OVL) step(0, 0, 1, 0, 40, 90, 1, 0, "R5");
        exp_cur = 90;
        hold(1, "R5");

        // R9: brownout while running is ignored
        step(0, 0, 1, 1, 90, -1, 1, 0, "R9");
        hold(3, "R9");

        // R6 / R7: shutdown, write while parked, two-step wake
        step(0, 0, 0, 0, -1, -1, 0, 1, "R6/R11");
        step(1, 20, 0, 0, -1, -1, 0, 1, "R7");
        step(0, 0, 0, 0, -1, -1, 0, 1, "R6");
        step(0, 0, 1, 0, 20, -1, 0, 0, "R7 wake");
        step(0, 0, 1, 0, 20, -1, 1, 0, "R7 hi restore");
        exp_cur = 20;
        hold(1, "R7");

        // R7: retention with no write
        step(0, 0, 0, 0, -1, -1, 0, 1, "R6");
        step(0, 0, 0, 0, -1, -1, 0, 1, "R6");
        step(0, 0, 1, 0, 20, -1, 0, 0, "R7 retain");
        step(0, 0, 1, 0, 20, -1, 1, 0, "R7 retain");

        // R8: brownout while parked, beats a simultaneous write
        step(0, 0, 0, 0, -1, -1, 0, 1, "R6");
        step(1, 99, 0, 1, -1, -1, 0, 1, "R8");
        step(0, 0, 1, 0, MID, -1, 0, 0, "R8");
        step(0, 0, 1, 0, MID, -1, 1, 0, "R8");
        exp_cur = MID;
        hold(1, "R8");

        // R10: shutdown aborts an overlap
        step(1, 10, 1, 0, MID, -1, 1, 0, "R10");
        step(0, 0, 1, 0, MID, 10, 1, 0, "R10");
        step(0, 0, 0, 0, -1, -1, 0, 1, "R10");
        step(1, 77, 0, 0, -1, -1, 0, 1, "R10");
        step(0, 0, 1, 0, 77, -1, 0, 0, "R10");
        step(0, 0, 1, 0, 77, -1, 1, 0, "R10");
        exp_cur = 77;
        hold(2, "R10");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule